// File: doc/BRIEF.md
# Sequential Integer and Fractional Divider

This block divides one 16-bit unsigned operand by another over a fixed run of cycles. It serves an execution unit that holds the dividend in its double accumulator and the divisor in an index register. A single-cycle start pulse captures both operands and a mode bit. Exactly 41 cycles later a one-cycle done pulse presents the results. The quotient is meant for the index register and the remainder for the accumulator. Writing them back is left to the surrounding pipeline.

There are two modes, and both run on one restoring shift-subtract datapath that produces one quotient bit per cycle. Integer mode returns the whole-number quotient and remainder. Fractional mode reads both operands as binary fractions of 2^16. It returns the dividend scaled by 2^16 and divided by the divisor, which is a 16-bit fraction. A zero divisor, or a fractional quotient that would not fit, gives an all-ones quotient. The zero, overflow and carry flags report the outcome.

Top module: `div16_seq`

## Requirements
- R1: With `mode_i` = 0 (integer) and a nonzero divisor, `quotient_o` = floor(dividend / divisor) and `remainder_o` = dividend mod divisor (for example 6 / 4 gives 1 remainder 2).
- R2: With `mode_i` = 1 (fractional), a nonzero divisor and dividend < divisor, `quotient_o` = floor(dividend * 65536 / divisor) and `remainder_o` = (dividend * 65536) mod divisor (for example 2 / 4 gives 0x8000 remainder 0).
- R3: A zero divisor in either mode gives `quotient_o` = 0xFFFF, `remainder_o` = dividend and `carry_o` = 1. In fractional mode it also sets `ovf_o` = 1.
- R4: In fractional mode with a nonzero divisor and divisor <= dividend, the result is `quotient_o` = 0xFFFF, `remainder_o` = dividend, `ovf_o` = 1 and `carry_o` = 0.
- R5: `zero_o` is 1 exactly when the delivered quotient is 0. In integer mode `ovf_o` is 0. With any nonzero divisor `carry_o` is 0.
- R6: `done_o` is high for exactly one cycle. It rises on the 41st rising clock edge after the edge that accepted `start_i`.
- R7: A start pulse that arrives while an operation is in progress is ignored. It changes neither the results of the operation in progress nor its done timing, and it produces no extra done pulse.
- R8: `quotient_o`, `remainder_o` and the flags change only on the edge that raises `done_o`. They hold through any later input activity until the next operation completes.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| mode_i | input | 1 | 0 selects integer division, 1 selects fractional division |
| dividend_i | input | 16 | Unsigned dividend, captured on an accepted start |
| divisor_i | input | 16 | Unsigned divisor, captured on an accepted start |
| quotient_o | output | 16 | Quotient (destined for the index register) |
| remainder_o | output | 16 | Remainder (destined for the accumulator) |
| zero_o | output | 1 | Quotient is zero |
| ovf_o | output | 1 | Fractional result does not fit, or divide by zero in fractional mode |
| carry_o | output | 1 | Divide by zero |
| done_o | output | 1 | One-cycle pulse when the results update |

## Verification
The assertions assume that `start_i` is sampled as a level on each rising edge. They also assume the operands and mode only matter in the cycle a start is accepted, so the latency counter in the checker restarts only on an accepted start. The stimulus drives `start_i` high for one cycle on the falling edge and changes the operands freely between operations. It also fires one deliberate start in the middle of a busy period. The scoreboard expects nothing from that start, so a stray result from it would be caught.

// File: rtl/div16_pkg.sv
package div16_pkg;
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } div_mode_e;

  typedef struct packed {
    logic z;
    logic v;
    logic c;
  } div_flags_t;
endpackage

// File: rtl/div16_step.sv
// one restoring iteration: shift in next bit, trial subtract, keep if no borrow
module div16_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] sh;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    sh    = {rem_i, quo_i[W-1]};
    ge    = sh >= {1'b0, dvs_i};
    diff  = sh - {1'b0, dvs_i};
    rem_o = ge ? diff[W-1:0] : sh[W-1:0];
    quo_o = {quo_i[W-2:0], ge};
  end
endmodule

// File: rtl/div16_ctrl.sv
module div16_ctrl #(
  parameter int ITER = 16,
  parameter int LAT  = 41
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  localparam int CW = $clog2(LAT);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i & ~busy_q;
  assign step_o   = busy_q && (cnt_q < CW'(ITER));
  assign finish_o = busy_q && (cnt_q == CW'(LAT - 1));
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (finish_o) busy_q <= 1'b0;
      else          cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/div16_core.sv
module div16_core import div16_pkg::*; #(
  parameter int W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  div_mode_e  mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output div_mode_e  mode_o,
  output logic [W-1:0] dvd_o,
  output logic [W-1:0] dvs_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_q, quo_q, dvd_q, dvs_q;
  logic [W-1:0] rem_n, quo_n;
  div_mode_e    mode_q;

  div16_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvs_i (dvs_q),
    .rem_o (rem_n),
    .quo_o (quo_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
      mode_q <= MODE_INT;
    end else if (load_i) begin
      // fractional: dividend seeds the partial remainder, zeros feed in below
      rem_q  <= (mode_i == MODE_FRAC) ? dividend_i : '0;
      quo_q  <= (mode_i == MODE_FRAC) ? '0 : dividend_i;
      dvd_q  <= dividend_i;
      dvs_q  <= divisor_i;
      mode_q <= mode_i;
    end else if (step_i) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
    end
  end

  assign mode_o = mode_q;
  assign dvd_o  = dvd_q;
  assign dvs_o  = dvs_q;
  assign rem_o  = rem_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/div16_fixup.sv
// substitutes saturated results for zero divisor and fractional overflow
module div16_fixup import div16_pkg::*; #(
  parameter int W = 16
) (
  input  div_mode_e    mode_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output div_flags_t   flags_o
);
  logic dz, fovf, sat;

  always_comb begin
    dz        = (dvs_i == '0);
    fovf      = (mode_i == MODE_FRAC) && (dvs_i <= dvd_i);
    sat       = dz | fovf;
    quo_o     = sat ? '1 : quo_i;
    rem_o     = sat ? dvd_i : rem_i;
    flags_o.c = dz;
    flags_o.v = fovf;
    flags_o.z = (quo_o == '0);
  end
endmodule

// File: rtl/div16_seq.sv
module div16_seq import div16_pkg::*; #(
  parameter int W   = 16,
  parameter int LAT = 41
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         zero_o,
  output logic         ovf_o,
  output logic         carry_o,
  output logic         done_o
);
  localparam int ITER = W;

  logic         accept_w, step_w, finish_w, busy_w;
  div_mode_e    mode_in, mode_w;
  logic [W-1:0] dvd_w, dvs_w, rem_w, quo_w, fq_w, fr_w;
  div_flags_t   flags_w;

  assign mode_in = div_mode_e'(mode_i);

  div16_ctrl #(.ITER(ITER), .LAT(LAT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept_w),
    .step_o   (step_w),
    .finish_o (finish_w),
    .busy_o   (busy_w)
  );

  div16_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept_w),
    .step_i     (step_w),
    .mode_i     (mode_in),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .mode_o     (mode_w),
    .dvd_o      (dvd_w),
    .dvs_o      (dvs_w),
    .rem_o      (rem_w),
    .quo_o      (quo_w)
  );

  div16_fixup #(.W(W)) u_fix (
    .mode_i  (mode_w),
    .dvd_i   (dvd_w),
    .dvs_i   (dvs_w),
    .rem_i   (rem_w),
    .quo_i   (quo_w),
    .quo_o   (fq_w),
    .rem_o   (fr_w),
    .flags_o (flags_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quotient_o  <= '0;
      remainder_o <= '0;
      zero_o      <= 1'b0;
      ovf_o       <= 1'b0;
      carry_o     <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= finish_w;
      if (finish_w) begin
        quotient_o  <= fq_w;
        remainder_o <= fr_w;
        zero_o      <= flags_w.z;
        ovf_o       <= flags_w.v;
        carry_o     <= flags_w.c;
      end
    end
  end
endmodule

// File: rtl/div16_chk.sv
module div16_chk #(
  parameter int W   = 16,
  parameter int LAT = 41
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_q,
  input logic         mode_q,
  input logic [W-1:0] dvs_q,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic         zero_o,
  input logic         ovf_o,
  input logic         carry_o,
  input logic         done_o
);
  localparam int CW = $clog2(LAT + 2);

  logic          run_q;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cyc_q <= '0;
    end else if (start_i && !busy_q) begin
      run_q <= 1'b1;
      cyc_q <= '0;
    end else if (run_q) begin
      if (done_o) run_q <= 1'b0;
      else if (cyc_q != '1) cyc_q <= cyc_q + 1'b1;
    end
  end

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_q && cyc_q == CW'(LAT)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(dvs_q));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(quotient_o) || !$stable(remainder_o) || !$stable(ovf_o) || !$stable(carry_o)) |-> done_o);

  p_div_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && carry_o) |-> (quotient_o == '1));

  p_frac_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf_o) |-> (quotient_o == '1));

  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == (quotient_o == '0)));

  p_int_no_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mode_q) |-> !ovf_o);
endmodule

bind div16_seq div16_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_q      (busy_w),
  .mode_q      (mode_w),
  .dvs_q       (dvs_w),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .zero_o      (zero_o),
  .ovf_o       (ovf_o),
  .carry_o     (carry_o),
  .done_o      (done_o)
);

// File: tb/div16_seq_tb.sv
`timescale 1ns/1ps
module div16_seq_tb;
  localparam int W   = 16;
  localparam int LAT = 41;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic [W-1:0] quo, rem;
  logic         zf, vf, cf, done;

  always #2.5 clk = ~clk;

  div16_seq #(.W(W), .LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .dividend_i(dvd), .divisor_i(dvs),
    .quotient_o(quo), .remainder_o(rem),
    .zero_o(zf), .ovf_o(vf), .carry_o(cf), .done_o(done)
  );

  typedef struct {
    logic [W-1:0] q, r;
    logic z, v, c;
    int   t;
    string req;
  } exp_t;

  exp_t sb[$];
  exp_t last;
  int   cyc = 0, checks = 0, fails = 0;
  bit   prev_done = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(bit m, logic [W-1:0] n, logic [W-1:0] d, string req);
    exp_t e;
    logic [2*W-1:0] num;
    e.req = req; e.c = 0; e.v = 0;
    if (d == 0) begin
      e.q = '1; e.r = n; e.c = 1; e.v = m;
    end else if (!m) begin
      e.q = n / d; e.r = n % d;
    end else if (n >= d) begin
      e.q = '1; e.r = n; e.v = 1;
    end else begin
      num = {n, {W{1'b0}}};
      e.q = W'(num / {{W{1'b0}}, d});
      e.r = W'(num % {{W{1'b0}}, d});
    end
    e.z = (e.q == 0);
    e.t = 0;
    return e;
  endfunction

  task automatic issue(bit m, logic [W-1:0] n, logic [W-1:0] d, string req);
    exp_t e;
    @(negedge clk);
    e = model(m, n, d, req);
    e.t = cyc + 1 + LAT;
    sb.push_back(e);
    mode = m; dvd = n; dvs = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(bit m, logic [W-1:0] n, logic [W-1:0] d, string req);
    issue(m, n, d, req);
    drain();
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(0, "R6", "done wider than one cycle", 1, 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(quo == e.q, e.req, "quotient", quo, e.q);
          chk(rem == e.r, e.req, "remainder", rem, e.r);
          chk({zf, vf, cf} == {e.z, e.v, e.c}, {e.req, "/R5"}, "flags zvc", {zf, vf, cf}, {e.z, e.v, e.c});
          chk(cyc == e.t, "R6", "done cycle", cyc, e.t);
          last = e;
        end
      end
      prev_done = done;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({quo, rem, zf, vf, cf, done} == '0, "R9", "outputs in reset", {quo, rem, zf, vf, cf, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 0 && quo == 0, "R9", "idle after reset", {done, quo}, 0);

    op(0, 16'd6, 16'd4, "R1");
    op(1, 16'd2, 16'd4, "R2");
    op(0, 16'd3, 16'd7, "R1");
    op(0, 16'hFFFF, 16'd1, "R1");
    op(0, 16'd0, 16'd5, "R1");
    op(1, 16'd1, 16'hFFFF, "R2");
    op(1, 16'd0, 16'd9, "R2");
    op(0, 16'd5, 16'd0, "R3");
    op(1, 16'd3, 16'd0, "R3");
    op(1, 16'd4, 16'd4, "R4");
    op(1, 16'hF000, 16'h1234, "R4");

    // R7: start during busy is ignored
    issue(0, 16'd1000, 16'd7, "R7");
    repeat (5) @(negedge clk);
    mode = 1; dvd = 16'd1; dvs = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 9) @(negedge clk);
    start = 1'b1; dvd = 16'd9; dvs = 16'd3;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (LAT + 5) @(negedge clk);
    chk(sb.size() == 0, "R7", "no extra result", sb.size(), 0);

    // R8: results hold while inputs wander without start
    op(0, 16'd500, 16'd3, "R8");
    for (int i = 0; i < 20; i++) begin
      dvd = 16'(i * 77); dvs = 16'(i); mode = i[0];
      @(negedge clk);
    end
    chk(quo == last.q && rem == last.r, "R8", "hold after done", {quo, rem}, {last.q, last.r});

    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] n, d;
      bit m;
      n = W'($urandom);
      d = W'($urandom) >> (i % 8);
      m = i[1];
      if (m && i[2]) n = n >> 8;
      op(m, n, d, m ? "R2" : "R1");
    end

    drain();
    summary();
  end
endmodule